// File: doc/BRIEF.md
# Dual-Channel Fan PWM Generator

This block produces two independent pulse-width-modulated fan drive outputs from one system clock. Each channel has an 8-bit configuration register. It holds a 6-bit duty code, a force-high bit and one rate bit. A 4-bit control register, shared by both channels, adds two more rate bits per channel. The three rate bits of a channel pick one of eight output frequencies. Four of them lie in the kHz range and four in the tens-of-Hz range.

Each channel splits one output period into 64 equal phase steps. The output is high during the first `duty` steps. The step rate is 64 times the selected output frequency, and it comes from a divider of the system clock. The divider values are computed from three parameters: the system clock rate, the fast base tick rate and the slow base tick rate. A new duty code or a new rate takes effect only when a period starts. The force bit acts at once.

Software reaches the three registers through a simple synchronous port with write-enable and read-enable. Read data appears one clock after the read request.

Top module: `fan_pwm_dual`

## Requirements
- R1: While reset is held, and in the first cycle after it, both fan outputs are 0. Every register reads back as 0.
- R2: A write to one of the three addresses updates that register. A read returns the register value on `rdata` in the cycle after `rd_en`. The fan 1 register is at `FAN_BASE_ADDR` and fan 2 at `FAN_BASE_ADDR+1`. The control register is at `CTRL_ADDR` and keeps only bits 3:0, so its bits 7:4 read 0. An address outside these three reads 0 and a write to it changes nothing.
- R3: When bit 0 of a fan register is 1, that channel's output is 1 from the cycle after the write, whatever the other bits hold.
- R4: When the duty field (bits 6:1) of a fan register is 0 and bit 0 is 0, the output stays 0 for whole periods once the current period has ended.
- R5: For a duty field n between 1 and 63, each period is 64·D clock cycles long, where D is the divisor of the selected rate. The output is 1 for the first n·D cycles of the period and 0 for the rest.
- R6: The rate code is {control bit 2+ch, control bit ch, fan register bit 7}, where ch is 0 for fan 1 and 1 for fan 2. The middle bit selects the slow base tick rate instead of the fast one. The top bit doubles the tick rate. The low bit multiplies it by 1.5. D is the system clock rate divided by the resulting tick rate, truncated.
- R7: A change of duty field or rate code written during a period leaves the rest of that period unchanged. The new setting applies from the next period start on.
- R8: Each channel's period and duty depend only on its own fan register and its own two control bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| fan_out | output | N_CH (2) | PWM drive, bit 0 is fan 1 |

## Verification
A write lands on the clock edge that samples `wr_en`. A forced output rises in the cycle after that edge, and read data is due one edge after `rd_en`. The bench drives on the falling edge and checks these results on the next falling edge. Duty and rate changes wait for a period start, so the bench never assumes a cycle for them. It first waits for a rising output edge, then counts cycles up to the next rising edge, and checks both the period length and the number of high cycles against arithmetic expectations. For the mid-period change, it counts the high run that was already in progress while the write lands.

// File: rtl/fanpwm_pkg.sv
// Shared constants, register layouts and the divisor calculation of the
// fan PWM generator. Assumes the base tick rates are non-zero.
package fanpwm_pkg;

    localparam int unsigned DUTY_W      = 6;
    localparam int unsigned PHASE_STEPS = 1 << DUTY_W;
    localparam int unsigned RATE_CODES  = 8;

    // Per-channel fan register, bit 7 down to bit 0.
    typedef struct packed {
        logic              clk_sel;
        logic [DUTY_W-1:0] duty;
        logic              force_hi;
    } fan_cfg_t;

    // Three-bit rate selection of one channel.
    typedef struct packed {
        logic mult;
        logic src;
        logic sel;
    } rate_code_t;

    // Clock cycles per phase tick for one rate code (never below 1).
    function automatic int unsigned tick_divisor(
        input int unsigned clk_hz,
        input int unsigned fast_hz,
        input int unsigned slow_hz,
        input int unsigned code
    );
        longint unsigned base;
        longint unsigned num;
        longint unsigned den;
        longint unsigned quo;
        base = ((code >> 1) & 1) != 0 ? longint'(slow_hz) : longint'(fast_hz);
        num  = 2 * longint'(clk_hz);
        den  = base * (((code >> 2) & 1) != 0 ? 2 : 1) * ((code & 1) != 0 ? 3 : 2);
        quo  = (den == 0) ? 1 : num / den;
        return (quo == 0) ? 1 : int'(quo);
    endfunction

endpackage

// File: rtl/fanpwm_regs.sv
// Register file of the fan PWM generator: one fan register per channel
// at consecutive addresses, and one shared control register.
// Assumes N_CH <= 4 so the control bits fit in one data byte.
module fanpwm_regs
    import fanpwm_pkg::*;
#(
    parameter int unsigned N_CH          = 2,
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned FAN_BASE_ADDR = 'h56,
    parameter int unsigned CTRL_ADDR     = 'h58
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output fan_cfg_t [N_CH-1:0]  fan_cfg,
    output logic [2*N_CH-1:0]    ctrl_cfg
);

    localparam int unsigned CTRL_W = 2 * N_CH;

    logic [DATA_W-1:0] rd_mux;
    logic              ctrl_hit;

    assign ctrl_hit = (addr == ADDR_W'(CTRL_ADDR));

    // One write port per fan register.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_fan
        logic fan_hit;
        assign fan_hit = (addr == ADDR_W'(FAN_BASE_ADDR + ch));

        // Capture the written byte when this channel's address matches.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fan_cfg[ch] <= '0;
            end else if (wr_en && fan_hit) begin
                fan_cfg[ch] <= fan_cfg_t'(wdata[$bits(fan_cfg_t)-1:0]);
            end
        end
    end

    // Capture the implemented low bits of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_cfg <= '0;
        end else if (wr_en && ctrl_hit) begin
            ctrl_cfg <= wdata[CTRL_W-1:0];
        end
    end

    // Select the addressed register; unmapped addresses give zero.
    always_comb begin
        rd_mux = '0;
        for (int ch = 0; ch < int'(N_CH); ch++) begin
            if (addr == ADDR_W'(FAN_BASE_ADDR + ch)) begin
                rd_mux = DATA_W'(fan_cfg[ch]);
            end
        end
        if (ctrl_hit) begin
            rd_mux = DATA_W'(ctrl_cfg);
        end
    end

    // Register the read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/fanpwm_prescaler.sv
// Divides the system clock down to the phase tick rate of one channel.
// Holds one limit per rate code. Assumes the code only changes in the
// cycle of a tick, so the counter always restarts from zero after a change.
module fanpwm_prescaler
    import fanpwm_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 24_000_000,
    parameter int unsigned FAST_TICK_HZ = 1_000_000,
    parameter int unsigned SLOW_TICK_HZ = 2_560
) (
    input  logic       clk,
    input  logic       rst_n,
    input  rate_code_t code,
    output logic       tick
);

    localparam int unsigned DIV_SLOW = tick_divisor(CLK_HZ, FAST_TICK_HZ, SLOW_TICK_HZ, 2);
    localparam int unsigned DIV_FAST = tick_divisor(CLK_HZ, FAST_TICK_HZ, SLOW_TICK_HZ, 0);
    localparam int unsigned MAX_DIV  = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int unsigned CNT_W    = $clog2(MAX_DIV + 1);

    logic [CNT_W-1:0] limit [RATE_CODES];
    logic [CNT_W-1:0] cnt;

    // Terminal count for every rate code, fixed at elaboration.
    for (genvar c = 0; c < RATE_CODES; c++) begin : g_limit
        assign limit[c] = CNT_W'(tick_divisor(CLK_HZ, FAST_TICK_HZ, SLOW_TICK_HZ, c) - 1);
    end

    assign tick = (cnt == limit[3'(code)]);

    // Count clock cycles and restart at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fanpwm_channel.sv
// One PWM channel. A 6-bit phase counter steps once per prescaler tick.
// Duty and rate are copied from the requested values only at the phase
// wrap, so a period always completes with one setting. The force bit
// bypasses the comparison at once.
module fanpwm_channel
    import fanpwm_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 24_000_000,
    parameter int unsigned FAST_TICK_HZ = 1_000_000,
    parameter int unsigned SLOW_TICK_HZ = 2_560
) (
    input  logic       clk,
    input  logic       rst_n,
    input  fan_cfg_t   cfg,
    input  rate_code_t code_req,
    output logic       pwm
);

    logic              tick;
    logic              wrap;
    logic [DUTY_W-1:0] phase;
    logic [DUTY_W-1:0] act_duty;
    rate_code_t        act_code;

    fanpwm_prescaler #(
        .CLK_HZ       (CLK_HZ),
        .FAST_TICK_HZ (FAST_TICK_HZ),
        .SLOW_TICK_HZ (SLOW_TICK_HZ)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (act_code),
        .tick  (tick)
    );

    assign wrap = (phase == DUTY_W'(PHASE_STEPS - 1));

    // Advance the phase; at the wrap load the pending duty and rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= '0;
            act_duty <= '0;
            act_code <= '0;
        end else if (tick) begin
            if (wrap) begin
                phase    <= '0;
                act_duty <= cfg.duty;
                act_code <= code_req;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    // High during the first act_duty steps, or always when forced.
    always_comb begin
        pwm = cfg.force_hi | (phase < act_duty);
    end

endmodule

// File: rtl/fan_pwm_dual.sv
// Top of the fan PWM generator: a register file and one PWM channel per
// fan. Channel ch takes its rate code from control bits N_CH+ch and ch
// and from bit 7 of its fan register. Assumes one clock and synchronous
// active-low reset.
module fan_pwm_dual
    import fanpwm_pkg::*;
#(
    parameter int unsigned N_CH          = 2,
    parameter int unsigned CLK_HZ        = 24_000_000,
    parameter int unsigned FAST_TICK_HZ  = 1_000_000,
    parameter int unsigned SLOW_TICK_HZ  = 2_560,
    parameter int unsigned FAN_BASE_ADDR = 'h56,
    parameter int unsigned CTRL_ADDR     = 'h58
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [7:0]      addr,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    output logic [N_CH-1:0] fan_out
);

    fan_cfg_t [N_CH-1:0]   fan_cfg;
    logic     [2*N_CH-1:0] ctrl_cfg;

    fanpwm_regs #(
        .N_CH          (N_CH),
        .ADDR_W        (8),
        .DATA_W        (8),
        .FAN_BASE_ADDR (FAN_BASE_ADDR),
        .CTRL_ADDR     (CTRL_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .fan_cfg  (fan_cfg),
        .ctrl_cfg (ctrl_cfg)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        rate_code_t code_req;

        assign code_req.mult = ctrl_cfg[N_CH + ch];
        assign code_req.src  = ctrl_cfg[ch];
        assign code_req.sel  = fan_cfg[ch].clk_sel;

        fanpwm_channel #(
            .CLK_HZ       (CLK_HZ),
            .FAST_TICK_HZ (FAST_TICK_HZ),
            .SLOW_TICK_HZ (SLOW_TICK_HZ)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg      (fan_cfg[ch]),
            .code_req (code_req),
            .pwm      (fan_out[ch])
        );
    end

endmodule

// File: rtl/fanpwm_checker.sv
// Protocol and output properties of fan_pwm_dual, attached by bind.
module fanpwm_checker
    import fanpwm_pkg::*;
#(
    parameter int unsigned N_CH          = 2,
    parameter int unsigned FAN_BASE_ADDR = 'h56,
    parameter int unsigned CTRL_ADDR     = 'h58
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_en,
    input logic [7:0]          addr,
    input logic [7:0]          rdata,
    input logic [N_CH-1:0]     fan_out,
    input fan_cfg_t [N_CH-1:0] fan_cfg
);

    AST_OUT_LOW_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> fan_out == '0);                                   // R1

    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && addr == 8'(CTRL_ADDR)) |-> (rdata >> (2 * N_CH)) == 8'd0); // R2

    AST_FAN1_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && addr == 8'(FAN_BASE_ADDR)) |-> rdata == 8'($past(fan_cfg[0]))); // R2

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_prop
        AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            fan_cfg[ch].force_hi |-> fan_out[ch]);                         // R3
    end

endmodule

bind fan_pwm_dual fanpwm_checker #(
    .N_CH          (N_CH),
    .FAN_BASE_ADDR (FAN_BASE_ADDR),
    .CTRL_ADDR     (CTRL_ADDR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .addr    (addr),
    .rdata   (rdata),
    .fan_out (fan_out),
    .fan_cfg (fan_cfg)
);

// File: tb/sim_fan_pwm_dual.sv
// Sweeps duty codes and all rate codes on a scaled-down clock setting.
module sim_fan_pwm_dual;

    localparam int unsigned CLK_HZ = 96;
    localparam int unsigned FAST_B = 4;
    localparam int unsigned SLOW_B = 1;
    localparam logic [7:0]  FAN1_A = 8'h56;
    localparam logic [7:0]  FAN2_A = 8'h57;
    localparam logic [7:0]  CTRL_A = 8'h58;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] fan_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fan_pwm_dual #(
        .N_CH (2), .CLK_HZ (CLK_HZ), .FAST_TICK_HZ (FAST_B), .SLOW_TICK_HZ (SLOW_B),
        .FAN_BASE_ADDR ('h56), .CTRL_ADDR ('h58)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
        .addr (addr), .wdata (wdata), .rdata (rdata), .fan_out (fan_out)
    );

    task automatic check(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // Divisor from R6: tick rate = base * (mult ? 2 : 1) * (sel ? 1.5 : 1).
    function automatic int exp_div(input int code);
        real rate;
        rate = ((code & 2) != 0) ? real'(SLOW_B) : real'(FAST_B);
        if ((code & 4) != 0) rate = rate * 2.0;
        if ((code & 1) != 0) rate = rate * 1.5;
        return int'($floor(real'(CLK_HZ) / rate));
    endfunction

    task automatic wait_rise(input int ch);
        logic prev;
        prev = fan_out[ch];
        forever begin
            @(negedge clk);
            if (!prev && fan_out[ch]) break;
            prev = fan_out[ch];
        end
    endtask

    // From a rising edge, count cycles and high cycles up to the next one.
    task automatic measure(input int ch, output int period, output int high);
        logic prev;
        wait_rise(ch);
        period = 1; high = 1; prev = 1'b1;
        forever begin
            @(negedge clk);
            if (!prev && fan_out[ch]) break;
            period++;
            if (fan_out[ch]) high++;
            prev = fan_out[ch];
        end
    endtask

    task automatic count_high(input int ch, input int cycles, output int high);
        high = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (fan_out[ch]) high++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int per, hi, per2, hi2, run;

        repeat (4) @(negedge clk);
        check(fan_out, 0, "R1 outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(fan_out, 0, "R1 outputs after reset");
        rd(FAN1_A, d); check(d, 0, "R1 fan1 reg");
        rd(FAN2_A, d); check(d, 0, "R1 fan2 reg");
        rd(CTRL_A, d); check(d, 0, "R1 ctrl reg");
        count_high(0, 2000, hi); check(hi, 0, "R4 fan1 idle low");

        // R2 register access
        wr(FAN1_A, 8'hA4); wr(FAN2_A, 8'h3E); wr(CTRL_A, 8'hFF);
        rd(FAN1_A, d); check(d, 'hA4, "R2 fan1 readback");
        rd(FAN2_A, d); check(d, 'h3E, "R2 fan2 readback");
        rd(CTRL_A, d); check(d, 'h0F, "R2 ctrl upper bits zero");
        wr(8'h60, 8'hFF);
        rd(8'h60, d); check(d, 0, "R2 unmapped read");
        rd(FAN1_A, d); check(d, 'hA4, "R2 unmapped write ignored fan1");
        rd(FAN2_A, d); check(d, 'h3E, "R2 unmapped write ignored fan2");
        rd(CTRL_A, d); check(d, 'h0F, "R2 unmapped write ignored ctrl");
        wr(CTRL_A, 8'h00); wr(FAN1_A, 8'h00);

        // R3 force-high, then R4 zero duty
        wr(FAN2_A, 8'h01);
        check(fan_out[1], 1, "R3 force takes effect next cycle");
        count_high(1, 300, hi); check(hi, 300, "R3 forced dcc0");
        wr(FAN2_A, 8'h7F);
        count_high(1, 300, hi); check(hi, 300, "R3 forced dcc63");
        wr(FAN2_A, 8'h00);
        repeat (2 * 64 * exp_div(0) + 8) @(negedge clk);
        count_high(1, 3000, hi); check(hi, 0, "R4 fan2 dcc0 low");

        // R5 duty sweep at code 101 (ctrl bit2=1, fan bit7=1)
        wr(CTRL_A, 8'h04);
        for (int n = 1; n < 64; n += 2) begin
            wr(FAN1_A, 8'(8'h80 | (n << 1)));
            measure(0, per, hi);
            check(per, 64 * exp_div(5), $sformatf("R5 period dcc=%0d", n));
            check(hi, n * exp_div(5), $sformatf("R5 high dcc=%0d", n));
        end
        wr(FAN1_A, 8'h80 | (63 << 1));
        measure(0, per, hi);
        check(per - hi, exp_div(5), "R5 dcc63 low slice");

        // R6 every rate code on fan1, complementary code on fan2 (R8)
        for (int c = 0; c < 8; c++) begin
            int c2;
            c2 = 7 - c;
            wr(CTRL_A, 8'(((c2 >> 2) & 1) << 3 | ((c >> 2) & 1) << 2 |
                          ((c2 >> 1) & 1) << 1 | ((c >> 1) & 1)));
            wr(FAN1_A, 8'(((c & 1) << 7) | (20 << 1)));
            wr(FAN2_A, 8'(((c2 & 1) << 7) | (45 << 1)));
            fork
                measure(0, per, hi);
                measure(1, per2, hi2);
            join
            check(per, 64 * exp_div(c), $sformatf("R6 fan1 period code=%0d", c));
            check(hi, 20 * exp_div(c), $sformatf("R6 fan1 high code=%0d", c));
            check(per2, 64 * exp_div(c2), $sformatf("R8 fan2 period code=%0d", c2));
            check(hi2, 45 * exp_div(c2), $sformatf("R8 fan2 high code=%0d", c2));
        end

        // R7 mid-period change of duty and rate
        wr(CTRL_A, 8'h04); wr(FAN2_A, 8'h00);
        wr(FAN1_A, 8'hC0);
        measure(0, per, hi);
        wait_rise(0);
        fork
            begin
                run = 1;
                forever begin
                    @(negedge clk);
                    if (fan_out[0]) run++; else break;
                end
            end
            begin
                repeat (5) @(negedge clk);
                wr(FAN1_A, 8'h10);
            end
        join
        check(run, 32 * exp_div(5), "R7 old duty finishes period");
        measure(0, per, hi);
        check(per, 64 * exp_div(4), "R7 new rate next period");
        check(hi, 8 * exp_div(4), "R7 new duty next period");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule